// File: doc/BRIEF.md
# Retriggerable Monostable Interval Timer

This block is a one-shot interval timer. It runs on a fast system clock and counts rising edges of a separate slow time-base input, normally a 50 Hz square wave that gives one tick every 20 ms. A falling edge on the active-low trigger input starts a timing period. The output stays high until a parameterised number of ticks has been counted. With the default terminal count of 925 ticks the period is 18.5 s.

All three asynchronous inputs (trigger, time-base and mode) pass through a two-flop synchroniser before any logic uses them. A small four-state controller (idle, setup, timing, stop) drives a binary up counter of configurable width, which wraps around, and a terminal-count comparator. The mode input is read as a level. In retrigger mode a new trigger edge during a period restarts the count from zero, so the block acts as a watchdog. In the other mode such edges are ignored. Time-base ticks only advance the counter while a period is running.

Top module: `oneshot_timer`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a clock edge) returns the block to idle, clears the tick counter and drives `timer_out` low, including in the middle of a period.
- R2: A falling edge on `trig_n` seen in idle starts a period. `timer_out` is still low after the second clock edge following the input change and is high after the third.
- R3: Once started, `timer_out` stays high for exactly `TERM_COUNT` rising edges of `tbase` and falls within four clock edges after the last one.
- R4: Rising edges of `tbase` that arrive while idle are ignored. Any number of them before a trigger leaves the next period exactly `TERM_COUNT` ticks long.
- R5: With `mode_retrig` = 0, trigger falling edges during a running period have no effect on its length.
- R6: With `mode_retrig` = 1, a trigger falling edge during a running period restarts the count from zero without dropping `timer_out`. A period with retriggers after k1, k2, ... ticks lasts k1 + k2 + ... + `TERM_COUNT` ticks.
- R7: Only the falling edge of `trig_n` acts. Holding it low does not start a second period, and its rising edge does nothing.
- R8: The tick counter is `TICK_W` bits wide and wraps modulo 2^`TICK_W`. A `TERM_COUNT` of 0 therefore gives a period of 2^`TICK_W` ticks.
- R9: Every period passes through a setup state, which clears the counter, and ends in a stop state, which returns to idle. A new trigger right after a period ends is accepted normally.
- R10: `mode_retrig` is a level that is sampled when each trigger edge is evaluated. A change of the mode alone never starts a period, and a mode change during a period applies to later triggers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| trig_n | input | 1 | Trigger, active low; the falling edge starts or restarts a period |
| tbase | input | 1 | Slow time-base; each rising edge is one tick |
| mode_retrig | input | 1 | 1 = retriggerable, 0 = non-retriggerable (level) |
| timer_out | output | 1 | High while a timing period runs |

## Verification
The hardest case to reach from the ports is a retrigger that lands between two ticks in the middle of a period, because its effect shows only as a longer pulse counted in slow ticks. The bench aligns every trigger a few clocks after a falling edge of the time-base. This leaves no tick in flight, so the expected pulse length in ticks is an exact sum that the driver can queue before acting. A second, narrow instance with a zero terminal count reaches the counter wrap in a few ticks. A reset issued in the middle of a period shows that the following pulse starts from a cleared count.

// File: rtl/ost_pkg.sv
package ost_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_TIMING = 2'd2,
    ST_STOP   = 2'd3
  } ost_state_e;

  // edge kinds selectable on the synchroniser
  localparam int EDGE_RISE = 0;
  localparam int EDGE_FALL = 1;
  localparam int EDGE_ANY  = 2;

  // edge of a sampled level, by kind
  function automatic logic edge_seen(logic prev, logic cur, int kind);
    case (kind)
      EDGE_RISE: return !prev && cur;
      EDGE_FALL: return prev && !cur;
      default:   return prev != cur;
    endcase
  endfunction

  // output is high in the active part of the period
  function automatic logic period_active(ost_state_e s);
    return (s == ST_SETUP) || (s == ST_TIMING);
  endfunction

endpackage

// File: rtl/ost_insync.sv
module ost_insync
  import ost_pkg::*;
#(
  parameter int   STAGES    = 2,
  parameter logic RST_VAL   = 1'b0,
  parameter int   EDGE_KIND = EDGE_RISE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic edge_evt
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[0] <= RST_VAL;
          else        chain_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[g] <= RST_VAL;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= chain_q[LAST];
  end

  assign level    = chain_q[LAST];
  assign edge_evt = edge_seen(prev_q, chain_q[LAST], EDGE_KIND);

endmodule

// File: rtl/ost_fsm.sv
module ost_fsm
  import ost_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trig_fall,
  input  logic       retrig_mode,
  input  logic       tick,
  input  logic       term_hit,
  output ost_state_e state_q,
  output logic       cnt_clr,
  output logic       cnt_en,
  output logic       active
);

  ost_state_e state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (trig_fall) state_d = ST_SETUP;
      ST_SETUP:  state_d = ST_TIMING;
      ST_TIMING: begin
        if (trig_fall && retrig_mode) state_d = ST_SETUP;
        else if (term_hit)            state_d = ST_STOP;
      end
      ST_STOP:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign cnt_clr = (state_q == ST_SETUP);
  assign cnt_en  = (state_q == ST_TIMING) && tick;
  assign active  = period_active(state_q);

endmodule

// File: rtl/ost_counter.sv
module ost_counter #(
  parameter int          TICK_W     = 16,
  parameter int unsigned TERM_COUNT = 925
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  output logic [TICK_W-1:0] cnt_q,
  output logic              term_hit
);

  localparam logic [TICK_W-1:0] TERM_W = TICK_W'(TERM_COUNT);

  function automatic logic [TICK_W-1:0] step(logic [TICK_W-1:0] c);
    return c + 1'b1;
  endfunction

  function automatic logic reaches_term(logic [TICK_W-1:0] c);
    return step(c) == TERM_W;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (en)  cnt_q <= step(cnt_q);
  end

  assign term_hit = en && reaches_term(cnt_q);

endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
  import ost_pkg::*;
#(
  parameter int          TICK_W      = 16,
  parameter int unsigned TERM_COUNT  = 925,
  parameter int          SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_n,
  input  logic tbase,
  input  logic mode_retrig,
  output logic timer_out
);

  // named internal events, observed by the bound checker
  logic              trig_lvl, trig_fall;
  logic              tb_lvl, tb_rise;
  logic              mode_lvl, mode_evt;
  logic              cnt_clr, cnt_en, term_hit;
  logic [TICK_W-1:0] cnt_q;
  ost_state_e        state_q;

  ost_insync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1), .EDGE_KIND(EDGE_FALL)) u_trig_sync (
    .clk(clk), .rst_n(rst_n), .async_in(trig_n), .level(trig_lvl), .edge_evt(trig_fall)
  );

  ost_insync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0), .EDGE_KIND(EDGE_RISE)) u_tb_sync (
    .clk(clk), .rst_n(rst_n), .async_in(tbase), .level(tb_lvl), .edge_evt(tb_rise)
  );

  ost_insync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0), .EDGE_KIND(EDGE_ANY)) u_mode_sync (
    .clk(clk), .rst_n(rst_n), .async_in(mode_retrig), .level(mode_lvl), .edge_evt(mode_evt)
  );

  ost_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .trig_fall(trig_fall), .retrig_mode(mode_lvl),
    .tick(tb_rise), .term_hit(term_hit), .state_q(state_q),
    .cnt_clr(cnt_clr), .cnt_en(cnt_en), .active(timer_out)
  );

  ost_counter #(.TICK_W(TICK_W), .TERM_COUNT(TERM_COUNT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .en(cnt_en),
    .cnt_q(cnt_q), .term_hit(term_hit)
  );

endmodule

// File: rtl/ost_checker.sv
module ost_checker
  import ost_pkg::*;
#(
  parameter int TICK_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input ost_state_e        state_q,
  input logic [TICK_W-1:0] cnt_q,
  input logic              trig_lvl,
  input logic              trig_fall,
  input logic              tb_lvl,
  input logic              tb_rise,
  input logic              mode_lvl,
  input logic              mode_evt,
  input logic              term_hit,
  input logic              timer_out
);

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (state_q == ST_IDLE && cnt_q == '0 && !timer_out));

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && trig_fall) |=> (state_q == ST_SETUP && timer_out));

  p_fall_at_term_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(timer_out) |-> (state_q == ST_STOP && $past(term_hit)));

  p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TIMING && !tb_lvl) |=> $stable(cnt_q));

  p_idle_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !trig_fall) |=> (state_q == ST_IDLE && $stable(cnt_q)));

  p_nonretrig_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TIMING && trig_fall && !mode_lvl) |=> (state_q != ST_SETUP));

  p_retrig_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TIMING && trig_fall && mode_lvl) |=> (state_q == ST_SETUP && timer_out));

  p_held_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !trig_lvl && !trig_fall) |=> (state_q == ST_IDLE));

  p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TIMING && tb_rise && !trig_fall) |=> (cnt_q == $past(cnt_q) + 1'b1));

  p_setup_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SETUP) |=> (state_q == ST_TIMING && cnt_q == '0));

  p_stop_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STOP) |=> (state_q == ST_IDLE && !timer_out));

  p_mode_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && mode_evt && !trig_fall) |=> (state_q == ST_IDLE));

endmodule

bind oneshot_timer ost_checker #(.TICK_W(TICK_W)) u_ost_checker (
  .clk(clk), .rst_n(rst_n), .state_q(state_q), .cnt_q(cnt_q),
  .trig_lvl(trig_lvl), .trig_fall(trig_fall), .tb_lvl(tb_lvl), .tb_rise(tb_rise),
  .mode_lvl(mode_lvl), .mode_evt(mode_evt), .term_hit(term_hit), .timer_out(timer_out)
);

// File: tb/oneshot_timer_bench.sv
module oneshot_timer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int TB_HALF    = 10;   // clocks per half time-base period
  localparam int TERM       = 6;
  localparam int WRAP_W     = 3;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig_n = 1'b1;
  logic trig_w = 1'b1;
  logic tbase = 1'b0;
  logic mode = 1'b0;
  logic out_a, out_w;

  int checks = 0;
  int fails = 0;
  int tick_total = 0;
  int pending = 0;
  int exp_q[$];
  string tag_q[$];
  int len_w = 0;
  int pulses_w = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  oneshot_timer #(.TICK_W(16), .TERM_COUNT(TERM)) u_oneshot_timer (
    .clk(clk), .rst_n(rst_n), .trig_n(trig_n), .tbase(tbase),
    .mode_retrig(mode), .timer_out(out_a)
  );

  oneshot_timer #(.TICK_W(WRAP_W), .TERM_COUNT(0)) u_wrap (
    .clk(clk), .rst_n(rst_n), .trig_n(trig_w), .tbase(tbase),
    .mode_retrig(1'b0), .timer_out(out_w)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // time-base generator, counts its own rising edges
  initial begin
    forever begin
      repeat (TB_HALF) @(posedge clk);
      #1 tbase = ~tbase;
      if (tbase) tick_total++;
    end
  end

  // monitor for the main instance: pulse length in ticks vs scoreboard
  initial begin
    bit prev = 1'b0;
    int start = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) prev = 1'b0;
      else begin
        if (out_a && !prev) start = tick_total;
        if (!out_a && prev) begin
          if (exp_q.size() == 0) check(1'b0, "R3 unexpected pulse", tick_total - start, 0);
          else begin
            int e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check((tick_total - start) == e, t, tick_total - start, e);
            pending--;
          end
        end
        prev = out_a;
      end
    end
  end

  // monitor for the wrap instance
  initial begin
    bit prev = 1'b0;
    int start = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) prev = 1'b0;
      else begin
        if (out_w && !prev) start = tick_total;
        if (!out_w && prev) begin
          len_w = tick_total - start;
          pulses_w++;
        end
        prev = out_w;
      end
    end
  end

  task automatic expect_pulse(input int n, input string tag);
    exp_q.push_back(n);
    tag_q.push_back(tag);
    pending++;
  endtask

  // place the next action a few clocks into a low phase of the time-base
  task automatic align();
    @(negedge tbase);
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic after_ticks(input int k);
    repeat (k) @(posedge tbase);
    align();
  endtask

  task automatic fire(input bit from_idle);
    trig_n = 1'b0;
    if (from_idle) begin
      repeat (2) @(posedge clk);
      @(negedge clk);
      check(out_a == 1'b0, "R2 latency low", out_a, 0);
      @(posedge clk);
      @(negedge clk);
      check(out_a == 1'b1, "R2 latency high", out_a, 1);
      @(posedge clk);
    end else begin
      repeat (4) @(posedge clk);
    end
    #1 trig_n = 1'b1;
  endtask

  task automatic wait_done();
    wait (pending == 0);
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(out_a == 1'b0, "R1 reset output", out_a, 0);
    check(out_w == 1'b0, "R1 reset output wrap", out_w, 0);
    @(posedge clk);
    #1 rst_n = 1'b1;

    // R4: idle ticks do not start or shorten anything
    repeat (5) @(posedge tbase);
    @(negedge clk);
    check(out_a == 1'b0, "R4 idle stays low", out_a, 0);
    align();
    expect_pulse(TERM, "R4 period after idle ticks");
    fire(1'b1);
    wait_done();

    // R3: plain period
    align();
    expect_pulse(TERM, "R3 single period");
    fire(1'b1);
    wait_done();

    // R5: non-retriggerable ignores a second edge
    align();
    expect_pulse(TERM, "R5 retrigger ignored");
    fire(1'b1);
    after_ticks(2);
    fire(1'b0);
    wait_done();

    // R6: retrigger restarts the count
    mode = 1'b1;
    align();
    expect_pulse(2 + TERM, "R6 single retrigger");
    fire(1'b1);
    after_ticks(2);
    fire(1'b0);
    wait_done();

    // R6: repeated retriggers keep the output high
    align();
    expect_pulse(4 * 4 + TERM, "R6 held high by retriggers");
    fire(1'b1);
    for (int i = 0; i < 4; i++) begin
      after_ticks(4);
      @(negedge clk);
      check(out_a == 1'b1, "R6 still high before retrigger", out_a, 1);
      @(posedge clk);
      #1;
      fire(1'b0);
    end
    wait_done();

    // R7: trigger held low through the whole period, then released
    align();
    expect_pulse(TERM, "R7 held low single period");
    trig_n = 1'b0;
    wait_done();
    repeat (3) @(posedge tbase);
    @(negedge clk);
    check(out_a == 1'b0, "R7 held low no restart", out_a, 0);
    align();
    trig_n = 1'b1;
    repeat (2) @(posedge tbase);
    @(negedge clk);
    check(out_a == 1'b0, "R7 rising edge no effect", out_a, 0);

    // R9: trigger accepted right after a period ends
    align();
    expect_pulse(TERM, "R9 back-to-back first");
    fire(1'b1);
    wait (pending == 0);
    repeat (2) @(posedge clk);
    #1;
    expect_pulse(TERM, "R9 back-to-back second");
    fire(1'b1);
    wait_done();

    // R10: mode is a level sampled at each trigger
    align();
    expect_pulse(TERM, "R10 mode cleared mid-period");
    fire(1'b1);
    after_ticks(1);
    mode = 1'b0;
    after_ticks(1);
    fire(1'b0);
    wait_done();
    align();
    mode = 1'b1;
    repeat (2) @(posedge tbase);
    @(negedge clk);
    check(out_a == 1'b0, "R10 mode change alone", out_a, 0);
    mode = 1'b0;

    // R1: reset during a period, next period starts from zero
    align();
    fire(1'b1);
    after_ticks(3);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(out_a == 1'b0, "R1 reset mid-period", out_a, 0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    align();
    expect_pulse(TERM, "R1 period after reset");
    fire(1'b1);
    wait_done();

    // R8: counter wrap with terminal count 0
    align();
    trig_w = 1'b0;
    repeat (4) @(posedge clk);
    #1 trig_w = 1'b1;
    wait (pulses_w == 1);
    check(len_w == (1 << WRAP_W), "R8 wrap period", len_w, 1 << WRAP_W);

    repeat (5) @(posedge clk);
    finish_run();
  end

endmodule